// File: doc/BRIEF.md
# Single-Outstanding Interrupt Request Dispatcher

This block gathers 64 level-sensitive interrupt lines and presents at most one of them at a time as a request. The request appears on a bank of 64 one-hot vector outputs and as a request number. The lower 32 lines come from expansion-bus slots and are gated in groups of four, each group sharing one mapping register. The upper 32 lines come from on-board devices, and each has its own mapping register. Bit 31 of each mapping register is the enable bit. The remaining bits are fixed at an identifying value and are never changed by writes.

A request stays raised until software retires it. Software can write a clear register that matches the request, or it can write a mapping register that disables the requesting source. After either kind of write, and after any mapping-register write, the block rescans. The rescan keeps a request that is still pending. If none is pending, it picks the lowest-numbered slot line that is high and enabled, and failing that the lowest-numbered on-board line. A rising slot line on an enabled group takes over the request at once, even if another request is pending. A rising on-board line takes the request only when nothing is pending.

The register port is a plain strobe, address and data interface with a combinational read. Address bits [7:6] select the register kind, and the low address bits give the index.

Top module: `irqd_dispatch`

## Requirements
- R1: During and after a synchronous active-low reset, `req_num` is 65, no `vec_req` bit is high, and every mapping register reads with bit 31 clear. Its lower bits keep their fixed value: slot group g reads 0x7C0 | (g<<2), and on-board register k reads 0x7E0 + k.
- R2: Writing a mapping register changes only bit 31 of its read value. Kind 0 is slot group map at index addr[2:0]; kind 1 is on-board map at index addr[4:0].
- R3: At most one `vec_req` bit is high, and it is bit `req_num`. `req_num` is either 0..63 or 65, and 65 means no request.
- R4: A rising slot line i whose group i/4 is enabled becomes the request on the next clock edge, replacing any pending request.
- R5: A rising on-board line 32+k with map k enabled becomes the request only if no request is pending.
- R6: A falling input never withdraws a request that has been issued.
- R7: A mapping-register write with bit 31 clear drops the pending request if that request belongs to the written register (a slot line in that group, or that exact on-board line).
- R8: Every mapping-register write is followed by a rescan. The rescan keeps a pending request. Otherwise it picks the lowest high, enabled slot line, then the lowest high, enabled on-board line, then 65. It uses the enable values being written in that cycle.
- R9: A slot clear write (kind 2, group addr[2:0]) retires the request and rescans only when req_num/4 equals the group; otherwise it is ignored.
- R10: An on-board clear write (kind 3, index addr[4:0]) retires the request and rescans only when `req_num` equals 32 + index; otherwise it is ignored.
- R11: Reads of either clear kind return 0.
- R12: A rising line whose mapping register is disabled creates no request.
- R13: When several enabled slot lines rise in the same cycle, the lowest-numbered one becomes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 64 | Interrupt line levels; [31:0] slot lines, [63:32] on-board lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address: [7:6] kind, low bits index |
| reg_wdata | input | 32 | Write data; only bit 31 is stored |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| vec_req | output | 64 | One-hot request vector |
| req_num | output | 7 | Pending request number, 65 when idle |

## Verification
Several corner cases are targeted on purpose:
- **Clearing a line that is still high.** The bench clears a request whose line is still high and expects the same number to be raised again. A design that rescanned the edge history instead of the held levels would go idle here.
- **Clears that almost match.** The bench issues clears for the wrong group and for the wrong on-board index. A design that did not compare the request number properly would retire the wrong request.
- **Preemption asymmetry.** A slot rise must preempt a pending on-board request, but an on-board rise must not. Swapping or unifying the two rules changes the request number seen.
- **Rescan with newly written enables.** Writing an enable while a line is already high must raise that line at once. A design that rescanned with the old enables would stay idle.
- **Simultaneous rises.** When several enabled slot lines rise in the same cycle, the lowest must win. A reversed scan would report the highest.

// File: rtl/irqd_pkg.sv
// Package: shared constants, register kinds and fixed map values for the
// interrupt dispatcher. Assumes two line classes of 32 each.
package irqd_pkg;
    localparam int PCI_LINES  = 32;
    localparam int OBD_LINES  = 32;
    localparam int GROUP_SZ   = 4;
    localparam int PCI_GROUPS = PCI_LINES / GROUP_SZ;
    localparam int SRC_LINES  = PCI_LINES + OBD_LINES;
    localparam int NUM_W      = $clog2(SRC_LINES + 2);
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int EN_BIT     = 31;
    localparam int GI_W       = $clog2(PCI_GROUPS);
    localparam int OI_W       = $clog2(OBD_LINES);
    localparam logic [NUM_W-1:0] NO_REQ = NUM_W'(SRC_LINES + 1);

    typedef enum logic [1:0] {
        K_PCI_MAP = 2'd0,
        K_OBD_MAP = 2'd1,
        K_PCI_CLR = 2'd2,
        K_OBD_CLR = 2'd3
    } reg_kind_e;

    // Fixed lower bits of slot group map g.
    function automatic logic [DATA_W-1:0] pci_map_fixed(input int unsigned g);
        return DATA_W'((32'h1F << 6) | (g << 2));
    endfunction

    // Fixed lower bits of on-board map k.
    function automatic logic [DATA_W-1:0] obd_map_fixed(input int unsigned k);
        return DATA_W'(((32'h1F << 6) | 32'h20) + k);
    endfunction
endpackage

// File: rtl/irqd_first.sv
// Lowest-index-first priority encoder.
// Assumes W >= 2; idx is zero when no bit is set.
module irqd_first #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one assigned.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqd_mapbank.sv
// Mapping-register bank: stores only the enable bits, builds the read value
// from fixed lower bits, and exposes the next-state enables so a rescan in
// the write cycle sees the value being written.
module irqd_mapbank
    import irqd_pkg::*;
#(
    parameter int NG = PCI_GROUPS,
    parameter int NO = OBD_LINES,
    parameter int GW = GI_W,
    parameter int OW = OI_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_pci,
    input  logic          wr_obd,
    input  logic          wr_bit,
    input  logic [GW-1:0] pci_idx,
    input  logic [OW-1:0] obd_idx,
    input  logic          rd_pci,
    input  logic          rd_obd,
    output logic [NG-1:0] pci_en_nxt,
    output logic [NO-1:0] obd_en_nxt,
    output logic [DW-1:0] rd_data
);
    logic [NG-1:0] pci_en_q;
    logic [NO-1:0] obd_en_q;

    // Per-register next enable: replaced only by a write to that index.
    for (genvar g = 0; g < NG; g++) begin : g_pci
        assign pci_en_nxt[g] = (wr_pci && pci_idx == GW'(g)) ? wr_bit : pci_en_q[g];
    end
    for (genvar k = 0; k < NO; k++) begin : g_obd
        assign obd_en_nxt[k] = (wr_obd && obd_idx == OW'(k)) ? wr_bit : obd_en_q[k];
    end

    // Enable storage; reset disables every source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_en_q <= '0;
            obd_en_q <= '0;
        end else begin
            pci_en_q <= pci_en_nxt;
            obd_en_q <= obd_en_nxt;
        end
    end

    // Read value: fixed lower bits with the stored enable in the top bit.
    always_comb begin
        rd_data = '0;
        if (rd_pci) begin
            rd_data = pci_map_fixed(int'(pci_idx));
            rd_data[EN_BIT] = pci_en_q[pci_idx];
        end else if (rd_obd) begin
            rd_data = obd_map_fixed(int'(obd_idx));
            rd_data[EN_BIT] = obd_en_q[obd_idx];
        end
    end
endmodule

// File: rtl/irqd_dispatch.sv
// Top: single-outstanding interrupt request dispatcher.
// Latches line levels, tracks one pending request, handles clear and map
// writes with a one-cycle rescan. Assumes synchronous inputs.
module irqd_dispatch
    import irqd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_LINES-1:0] src_lvl,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [SRC_LINES-1:0] vec_req,
    output logic [NUM_W-1:0]     req_num
);
    localparam int GSH  = $clog2(GROUP_SZ);
    localparam int PIW  = $clog2(PCI_LINES);
    localparam int OIW  = $clog2(OBD_LINES);

    reg_kind_e               kind;
    logic [GI_W-1:0]         pci_idx;
    logic [OI_W-1:0]         obd_idx;
    logic                    wr_pci_map, wr_obd_map, wr_pci_clr, wr_obd_clr;
    logic [PCI_GROUPS-1:0]   pci_en_nxt;
    logic [OBD_LINES-1:0]    obd_en_nxt;
    logic [PCI_LINES-1:0]    pci_en_line;
    logic [SRC_LINES-1:0]    lvl_q, rise;
    logic [NUM_W-1:0]        pend_q, pend_a, pend_b, pend_d;
    logic                    drop, clr_hit, rescan;
    logic                    sp_hit, so_hit, rp_hit, ro_hit;
    logic [PIW-1:0]          sp_idx, rp_idx;
    logic [OIW-1:0]          so_idx, ro_idx;

    // Register decode.
    always_comb begin
        kind       = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
        pci_idx    = reg_addr[GI_W-1:0];
        obd_idx    = reg_addr[OI_W-1:0];
        wr_pci_map = reg_wr && kind == K_PCI_MAP;
        wr_obd_map = reg_wr && kind == K_OBD_MAP;
        wr_pci_clr = reg_wr && kind == K_PCI_CLR;
        wr_obd_clr = reg_wr && kind == K_OBD_CLR;
    end

    irqd_mapbank u_maps (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pci     (wr_pci_map),
        .wr_obd     (wr_obd_map),
        .wr_bit     (reg_wdata[EN_BIT]),
        .pci_idx    (pci_idx),
        .obd_idx    (obd_idx),
        .rd_pci     (kind == K_PCI_MAP),
        .rd_obd     (kind == K_OBD_MAP),
        .pci_en_nxt (pci_en_nxt),
        .obd_en_nxt (obd_en_nxt),
        .rd_data    (reg_rdata)
    );

    // Fan each group enable out to its member lines.
    for (genvar i = 0; i < PCI_LINES; i++) begin : g_line_en
        assign pci_en_line[i] = pci_en_nxt[i / GROUP_SZ];
    end

    // Input level latch; a rise is a high level over a low latched value.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= src_lvl;
    end
    assign rise = src_lvl & ~lvl_q;

    irqd_first #(.W(PCI_LINES)) u_scan_pci (
        .vec (lvl_q[PCI_LINES-1:0] & pci_en_line), .hit (sp_hit), .idx (sp_idx));
    irqd_first #(.W(OBD_LINES)) u_scan_obd (
        .vec (lvl_q[SRC_LINES-1:PCI_LINES] & obd_en_nxt), .hit (so_hit), .idx (so_idx));
    irqd_first #(.W(PCI_LINES)) u_rise_pci (
        .vec (rise[PCI_LINES-1:0] & pci_en_line), .hit (rp_hit), .idx (rp_idx));
    irqd_first #(.W(OBD_LINES)) u_rise_obd (
        .vec (rise[SRC_LINES-1:PCI_LINES] & obd_en_nxt), .hit (ro_hit), .idx (ro_idx));

    // Next pending request: retire, rescan, then apply rising edges.
    always_comb begin
        drop = (wr_pci_map && !reg_wdata[EN_BIT] && pend_q < NUM_W'(PCI_LINES)
                    && (pend_q >> GSH) == NUM_W'(pci_idx))
            || (wr_obd_map && !reg_wdata[EN_BIT]
                    && pend_q == NUM_W'(PCI_LINES) + NUM_W'(obd_idx));
        clr_hit = (wr_pci_clr && (pend_q >> GSH) == NUM_W'(pci_idx))
               || (wr_obd_clr && pend_q == NUM_W'(PCI_LINES) + NUM_W'(obd_idx));
        rescan = wr_pci_map || wr_obd_map || clr_hit;
        pend_a = (drop || clr_hit) ? NO_REQ : pend_q;
        pend_b = pend_a;
        if (rescan && pend_a == NO_REQ) begin
            if (sp_hit)      pend_b = NUM_W'(sp_idx);
            else if (so_hit) pend_b = NUM_W'(PCI_LINES) + NUM_W'(so_idx);
        end
        pend_d = pend_b;
        if (rp_hit)                            pend_d = NUM_W'(rp_idx);
        else if (ro_hit && pend_b == NO_REQ)   pend_d = NUM_W'(PCI_LINES) + NUM_W'(ro_idx);
    end

    // Pending request register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= NO_REQ;
        else        pend_q <= pend_d;
    end

    // One-hot vector outputs decoded from the pending number.
    for (genvar v = 0; v < SRC_LINES; v++) begin : g_vec
        assign vec_req[v] = (pend_q == NUM_W'(v));
    end
    assign req_num = pend_q;
endmodule

// File: rtl/irqd_dispatch_chk.sv
// Checker bound to irqd_dispatch: port-level properties on the request
// outputs. Keeps its own copy of the previous input levels.
module irqd_dispatch_chk
    import irqd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [SRC_LINES-1:0] src_lvl,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic [SRC_LINES-1:0] vec_req,
    input logic [NUM_W-1:0]     req_num
);
    logic [SRC_LINES-1:0] prev_lvl;
    logic [SRC_LINES-1:0] seen_rise;

    // Previous levels, reset low like the input latch.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= src_lvl;
    end
    assign seen_rise = src_lvl & ~prev_lvl;

    p_rst_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (req_num == NO_REQ && vec_req == '0));

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_req));

    p_legal_num_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_num < NUM_W'(SRC_LINES) || req_num == NO_REQ)
        && ((req_num == NO_REQ) == (vec_req == '0)));

    p_obd_no_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_num != NO_REQ && !reg_wr && seen_rise[PCI_LINES-1:0] == '0)
        |=> $stable(req_num));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && seen_rise == '0) |=> $stable(req_num));

    p_clr_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[ADDR_W-1] |-> reg_rdata == '0);
endmodule

bind irqd_dispatch irqd_dispatch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .vec_req   (vec_req),
    .req_num   (req_num)
);

// File: tb/irqd_dispatch_bench.sv
// Bench for irqd_dispatch: a vector table walked by one loop, then directed
// tests for reset, map masking, clear reads and corner cases.
module irqd_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] vec_req;
    logic [6:0]  req_num;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irqd_dispatch u_irqd_dispatch (
        .clk (clk), .rst_n (rst_n), .src_lvl (src_lvl), .reg_wr (reg_wr),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .vec_req (vec_req), .req_num (req_num)
    );

    localparam logic [31:0] EN = 32'h8000_0000;
    localparam logic [63:0] S2  = 64'h0000_0000_0000_0004;
    localparam logic [63:0] S2X = 64'h0000_0002_0000_0004;
    localparam logic [63:0] S33 = 64'h0000_0002_0000_0000;
    localparam logic [63:0] S35 = 64'h0000_0002_0000_0020;
    localparam logic [63:0] S3A = 64'h0000_0002_0000_0022;
    localparam logic [63:0] S15 = 64'h0000_0000_0000_0022;
    localparam logic [63:0] S4A = 64'h0000_0004_0000_0022;
    localparam logic [63:0] S4B = 64'h0000_0004_0000_0002;

    // Row: {src, wr, addr, wdata, expected req_num}
    localparam logic [111:0] TBL [0:19] = '{
        {64'h0, 1'b1, 8'h00, EN,    7'd65}, // R8 enable group 0, nothing high
        {S2,    1'b0, 8'h00, 32'h0, 7'd2},  // R4 slot rise
        {S2X,   1'b0, 8'h00, 32'h0, 7'd2},  // R5 disabled on-board rise
        {S2X,   1'b1, 8'h41, EN,    7'd2},  // R8 rescan keeps pending
        {S2X,   1'b1, 8'h80, 32'h0, 7'd2},  // R9 clear, line still high
        {S33,   1'b0, 8'h00, 32'h0, 7'd2},  // R6 fall keeps request
        {S33,   1'b1, 8'h80, 32'h0, 7'd33}, // R9 clear then on-board pick
        {S33,   1'b1, 8'h80, 32'h0, 7'd33}, // R9 wrong group ignored
        {S35,   1'b0, 8'h00, 32'h0, 7'd33}, // R12 disabled group rise
        {S3A,   1'b0, 8'h00, 32'h0, 7'd1},  // R4 slot preempts
        {S3A,   1'b1, 8'hC1, 32'h0, 7'd1},  // R10 wrong on-board clear
        {S3A,   1'b1, 8'h00, 32'h0, 7'd33}, // R7 disable pending group
        {S3A,   1'b1, 8'hC1, 32'h0, 7'd33}, // R10 clear, line still high
        {S15,   1'b0, 8'h00, 32'h0, 7'd33}, // R6 fall keeps request
        {S15,   1'b1, 8'hC1, 32'h0, 7'd65}, // R10 clear, nothing enabled
        {S15,   1'b1, 8'h01, EN,    7'd5},  // R8 enable picks held line
        {S15,   1'b1, 8'h42, EN,    7'd5},  // R8 keeps pending
        {S4A,   1'b0, 8'h00, 32'h0, 7'd5},  // R5 on-board rise no preempt
        {S4B,   1'b0, 8'h00, 32'h0, 7'd5},  // R6 fall keeps request
        {S4B,   1'b1, 8'h81, 32'h0, 7'd34}  // R9 clear then on-board pick
    };

    function automatic string row_tag(input int r);
        case (r)
            1, 9:                 return "R4";
            2, 17:                return "R5";
            5, 13, 18:            return "R6";
            11:                   return "R7";
            0, 3, 15, 16:         return "R8";
            4, 6, 7, 19:          return "R9";
            10, 12, 14:           return "R10";
            default:              return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; returns at the next one.
    task automatic step(input logic [63:0] s, input logic w,
                        input logic [7:0] a, input logic [31:0] d);
        src_lvl = s; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, "read", {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    task automatic req_chk(input string tag, input logic [6:0] exp);
        check(tag, "req_num", {57'h0, req_num}, {57'h0, exp});
        check("R3", "vec_req", vec_req, (exp < 7'd64) ? (64'h1 << exp) : 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req_chk("R1", 7'd65);
        read_chk("R1", 8'h00, 32'h0000_07C0);
        read_chk("R1", 8'h40, 32'h0000_07E0);
        rst_n = 1'b1;

        for (int r = 0; r < 20; r++) begin
            step(TBL[r][111:48], TBL[r][47], TBL[r][46:39], TBL[r][38:7]);
            req_chk(row_tag(r), TBL[r][6:0]);
        end

        // R1: reset in mid-run clears request and enables.
        rst_n = 1'b0;
        step(64'h0, 1'b0, 8'h00, 32'h0);
        req_chk("R1", 7'd65);
        read_chk("R1", 8'h01, 32'h0000_07C4);
        read_chk("R1", 8'h42, 32'h0000_07E2);
        rst_n = 1'b1;

        // R2: only bit 31 follows the written data.
        step(64'h0, 1'b1, 8'h03, 32'hFFFF_FFFF);
        read_chk("R2", 8'h03, 32'h8000_07CC);
        step(64'h0, 1'b1, 8'h03, 32'h7FFF_FFFF);
        read_chk("R2", 8'h03, 32'h0000_07CC);
        step(64'h0, 1'b1, 8'h5F, 32'hFFFF_FFFF);
        read_chk("R2", 8'h5F, 32'h8000_07FF);
        step(64'h0, 1'b1, 8'h5F, 32'h0000_0000);
        read_chk("R2", 8'h5F, 32'h0000_07FF);

        // R11: clear registers read as zero.
        read_chk("R11", 8'h83, 32'h0);
        read_chk("R11", 8'hDF, 32'h0);

        // R12: rise on a disabled group leaves the block idle.
        step(64'h1000, 1'b0, 8'h00, 32'h0);
        req_chk("R12", 7'd65);
        // R8: enabling the group picks the line already high.
        step(64'h1000, 1'b1, 8'h03, EN);
        req_chk("R8", 7'd12);

        // R13: simultaneous enabled slot rises, lowest wins.
        step(64'h1000, 1'b1, 8'h01, EN);
        step(64'h1000, 1'b1, 8'h02, EN);
        req_chk("R8", 7'd12);
        step(64'h1240, 1'b0, 8'h00, 32'h0);
        req_chk("R13", 7'd6);

        // R6 then R9: drop all lines, clear group 1 leaves idle.
        step(64'h0, 1'b0, 8'h00, 32'h0);
        req_chk("R6", 7'd6);
        step(64'h0, 1'b1, 8'h81, 32'h0);
        req_chk("R9", 7'd65);

        // R5: enabled on-board rise with nothing pending.
        step(64'h0, 1'b1, 8'h45, EN);
        step(64'h0000_0020_0000_0000, 1'b0, 8'h00, 32'h0);
        req_chk("R5", 7'd37);
        step(64'h0000_0020_0000_0000, 1'b1, 8'hC4, 32'h0);
        req_chk("R10", 7'd37);
        // R7: disabling the pending on-board source retires it.
        step(64'h0000_0020_0000_0000, 1'b1, 8'h45, 32'h0);
        req_chk("R7", 7'd65);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule